// File: doc/BRIEF.md
# Telemetry byte stream encoder

This block merges three sources into one byte stream that a frame builder downstream sends one byte per frame. The sources are a receive-side UART byte stream, a pulse-per-second mark strobe, and two kinds of status report. One report carries the timestamp and delay code of the last pulse. The other carries the oscillator error and the trim setpoint. Two byte values are reserved. 0xBE stands for the pulse mark. 0xBD opens either a typed report or a stuffed data byte, so a receiver can take UART data back out of the stream unambiguously.

Report and mark strobes are latched and held pending until the output sequencer is idle. The sequencer then picks the most urgent source, preloads the whole sequence, and shifts it out on a valid/ready handshake. UART bytes go into a small FIFO. While the external blanking input is high they stay there, and they drain once it falls. Marks and reports are still sent while blanking is active.

Top module: `tlm_stream_enc`

## Requirements
- R1: After reset `out_vld` and `uart_ovf` are 0, and no report or mark is pending.
- R2: A mark request is sent as the single byte 0xBE. From an idle sequencer it appears on `out_byte` after the second clock edge following `mark_stb`.
- R3: A UART byte 0xBD is sent as the pair 0xBD 0x00, and a UART byte 0xBE is sent as the pair 0xBD 0x01.
- R4: Any other UART byte is sent as itself, once, in arrival order.
- R5: A timestamp report is 7 bytes: 0xBD, 0x14, `pps_ts` from most to least significant byte, then `pps_dly`. The values used are those of the latest `pps_stb`.
- R6: A frequency report is 8 bytes: 0xBD, 0x15, `frq_err` from most to least significant byte, then `frq_set` high byte and then low byte. The values used are those of the latest `frq_stb`.
- R7: Sources are chosen only while no sequence is in flight, in the order mark, timestamp report, frequency report, UART data. No sequence is interrupted. A request that arrives mid-sequence is served after the sequence ends, with one idle cycle between sequences.
- R8: While `blank` is 1, no UART byte leaves the FIFO. Bytes that arrive during that time are kept and sent after `blank` falls.
- R9: The FIFO holds `FIFO_DEPTH` (default 16) bytes. A UART byte that arrives while the FIFO is full (as seen before that clock edge) is dropped and sets `uart_ovf`, which stays at 1 until reset.
- R10: While `out_vld` is 1 and `out_rdy` is 0, `out_vld` and `out_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_vld | input | 1 | UART byte present this cycle |
| uart_data | input | 8 | UART byte |
| mark_stb | input | 1 | Pulse mark request |
| pps_stb | input | 1 | Timestamp report request, captures `pps_ts` and `pps_dly` |
| pps_ts | input | 32 | Timestamp of the previous pulse |
| pps_dly | input | 8 | Delay code of the previous pulse |
| frq_stb | input | 1 | Frequency report request, captures `frq_err` and `frq_set` |
| frq_err | input | 32 | Signed oscillator error, 0.1 ppb units |
| frq_set | input | 16 | Oscillator trim setpoint, 0 when no trimmable oscillator is present |
| blank | input | 1 | Hold UART bytes in the FIFO while 1 |
| out_rdy | input | 1 | Downstream accepts `out_byte` |
| out_vld | output | 1 | `out_byte` is valid |
| out_byte | output | 8 | Stream byte |
| uart_ovf | output | 1 | Sticky flag: a UART byte was dropped |

## Verification
A strobe or UART byte is registered at the first clock edge, loaded into the sequencer at the second edge, and visible on the outputs after that edge. Every later byte of the same sequence appears one edge after the previous byte is accepted. After the last byte is accepted there is one idle cycle before the next sequence. The bench steps a queue-based model at each rising edge using the inputs held across that edge, and it compares `out_vld`, `out_byte` and `uart_ovf` at the falling edge, so each result is sampled in the cycle it is due. Directed checks cover the reset state, the two-edge latency of a mark, and the overflow flag.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
   localparam logic [7:0] MARK_B    = 8'hBE;
   localparam logic [7:0] ESC_B     = 8'hBD;
   localparam logic [7:0] STUF_ESC  = 8'h00;
   localparam logic [7:0] STUF_MARK = 8'h01;
   localparam logic [7:0] TYP_PPS   = 8'h14;
   localparam logic [7:0] TYP_FRQ   = 8'h15;
   localparam int SEQ_BYTES = 8;
   localparam int SEQ_W     = SEQ_BYTES * 8;
   localparam int LEN_W     = $clog2(SEQ_BYTES + 1);
   localparam int PPS_W     = 40;
   localparam int FRQ_W     = 48;
endpackage

// File: rtl/tlm_fifo.sv
module tlm_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("tlm_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("tlm_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
   logic [CW-1:0] cnt;
   logic          full, push, pop;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign push  = wr && !full;
   assign pop   = rd && !empty;
   assign rdata = mem[rptr];

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
   end else begin : g_wrap
      assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
         ovf  <= 1'b0;
      end else begin
         if (push) wptr <= wptr_nx;
         if (pop)  rptr <= rptr_nx;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (wr && full) ovf <= 1'b1;
      end
   end

   a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   a_r9_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && full) |=> ovf);
   a_r9_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> cnt <= $past(cnt));
endmodule

// File: rtl/tlm_req_hold.sv
module tlm_req_hold #(
   parameter int W = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb,
   input  logic [W-1:0] din,
   input  logic         take,
   output logic         pend,
   output logic [W-1:0] dout
);
   if (W < 1) begin : g_bad_width
      $error("tlm_req_hold: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         dout <= '0;
      end else begin
         pend <= stb | (pend & ~take);
         if (stb) dout <= din;
      end
   end

   a_r7_take_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> pend);
   a_r7_stb_pends: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> pend);
endmodule

// File: rtl/tlm_seq.sv
module tlm_seq
   import tlm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mark_stb,
   input  logic             pps_pend,
   input  logic [PPS_W-1:0] pps_data,
   input  logic             frq_pend,
   input  logic [FRQ_W-1:0] frq_data,
   input  logic             blank,
   input  logic             fifo_empty,
   input  logic [7:0]       fifo_data,
   input  logic             out_rdy,
   output logic             pps_take,
   output logic             frq_take,
   output logic             fifo_pop,
   output logic             out_vld,
   output logic [7:0]       out_byte
);
   logic [SEQ_W-1:0] shreg, load_val;
   logic [LEN_W-1:0] left, load_len;
   logic             idle, mark_pend, mark_take, any_take;

   assign idle      = (left == '0);
   assign mark_take = idle && mark_pend;
   assign pps_take  = idle && !mark_pend && pps_pend;
   assign frq_take  = idle && !mark_pend && !pps_pend && frq_pend;
   assign fifo_pop  = idle && !mark_pend && !pps_pend && !frq_pend
                      && !blank && !fifo_empty;
   assign any_take  = mark_take | pps_take | frq_take | fifo_pop;

   always_comb begin
      load_val = '0;
      load_len = '0;
      if (mark_take) begin
         load_val = {MARK_B, {(SEQ_W-8){1'b0}}};
         load_len = LEN_W'(1);
      end else if (pps_take) begin
         load_val = {ESC_B, TYP_PPS, pps_data, {(SEQ_W-16-PPS_W){1'b0}}};
         load_len = LEN_W'(2 + PPS_W/8);
      end else if (frq_take) begin
         load_val = {ESC_B, TYP_FRQ, frq_data};
         load_len = LEN_W'(2 + FRQ_W/8);
      end else if (fifo_pop) begin
         if (fifo_data == ESC_B) begin
            load_val = {ESC_B, STUF_ESC, {(SEQ_W-16){1'b0}}};
            load_len = LEN_W'(2);
         end else if (fifo_data == MARK_B) begin
            load_val = {ESC_B, STUF_MARK, {(SEQ_W-16){1'b0}}};
            load_len = LEN_W'(2);
         end else begin
            load_val = {fifo_data, {(SEQ_W-8){1'b0}}};
            load_len = LEN_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg     <= '0;
         left      <= '0;
         mark_pend <= 1'b0;
      end else begin
         mark_pend <= mark_stb | (mark_pend & ~mark_take);
         if (idle) begin
            if (any_take) begin
               shreg <= load_val;
               left  <= load_len;
            end
         end else if (out_rdy) begin
            shreg <= shreg << 8;
            left  <= left - 1'b1;
         end
      end
   end

   assign out_vld  = !idle;
   assign out_byte = shreg[SEQ_W-1 -: 8];

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_rdy) |=> (out_vld && $stable(out_byte)));
   a_r7_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mark_take, pps_take, frq_take, fifo_pop}));
   a_r7_no_split: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> !(pps_take || frq_take || fifo_pop));
   a_r8_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> !fifo_pop);
   a_r2_mark_next: assert property (@(posedge clk) disable iff (!rst_n)
      mark_take |=> (out_vld && out_byte == MARK_B));
   a_r5_pps_head: assert property (@(posedge clk) disable iff (!rst_n)
      pps_take |=> (out_vld && out_byte == ESC_B));
endmodule

// File: rtl/tlm_stream_enc.sv
module tlm_stream_enc
   import tlm_pkg::*;
#(
   parameter int FIFO_DEPTH = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        uart_vld,
   input  logic [7:0]  uart_data,
   input  logic        mark_stb,
   input  logic        pps_stb,
   input  logic [31:0] pps_ts,
   input  logic [7:0]  pps_dly,
   input  logic        frq_stb,
   input  logic [31:0] frq_err,
   input  logic [15:0] frq_set,
   input  logic        blank,
   input  logic        out_rdy,
   output logic        out_vld,
   output logic [7:0]  out_byte,
   output logic        uart_ovf
);
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("tlm_stream_enc: FIFO_DEPTH must be at least 2");
   end

   logic             pps_pend, frq_pend, pps_take, frq_take;
   logic [PPS_W-1:0] pps_hold;
   logic [FRQ_W-1:0] frq_hold;
   logic             fifo_empty, fifo_pop;
   logic [7:0]       fifo_data;

   tlm_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr(uart_vld), .wdata(uart_data),
      .rd(fifo_pop), .rdata(fifo_data), .empty(fifo_empty), .ovf(uart_ovf)
   );

   tlm_req_hold #(.W(PPS_W)) u_pps_hold (
      .clk(clk), .rst_n(rst_n), .stb(pps_stb), .din({pps_ts, pps_dly}),
      .take(pps_take), .pend(pps_pend), .dout(pps_hold)
   );

   tlm_req_hold #(.W(FRQ_W)) u_frq_hold (
      .clk(clk), .rst_n(rst_n), .stb(frq_stb), .din({frq_err, frq_set}),
      .take(frq_take), .pend(frq_pend), .dout(frq_hold)
   );

   tlm_seq u_seq (
      .clk(clk), .rst_n(rst_n), .mark_stb(mark_stb),
      .pps_pend(pps_pend), .pps_data(pps_hold),
      .frq_pend(frq_pend), .frq_data(frq_hold),
      .blank(blank), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
      .out_rdy(out_rdy), .pps_take(pps_take), .frq_take(frq_take),
      .fifo_pop(fifo_pop), .out_vld(out_vld), .out_byte(out_byte)
   );

   a_r1_idle_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!out_vld && !uart_ovf));
endmodule

// File: tb/tlm_stream_enc_tb.sv
module tlm_stream_enc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        uart_vld = 1'b0;
   logic [7:0]  uart_data = '0;
   logic        mark_stb = 1'b0, pps_stb = 1'b0, frq_stb = 1'b0;
   logic [31:0] pps_ts = '0, frq_err = '0;
   logic [7:0]  pps_dly = '0;
   logic [15:0] frq_set = '0;
   logic        blank = 1'b0, out_rdy = 1'b1;
   logic        out_vld, uart_ovf;
   logic [7:0]  out_byte;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   string cur_req = "R1";

   logic [7:0]  q_fifo[$];
   logic [7:0]  q_seq[$];
   bit          m_p, p_p, f_p, m_ovf;
   logic [39:0] p_d;
   logic [47:0] f_d;

   always #4 clk = ~clk;

   tlm_stream_enc #(.FIFO_DEPTH(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .uart_vld(uart_vld), .uart_data(uart_data),
      .mark_stb(mark_stb), .pps_stb(pps_stb), .pps_ts(pps_ts), .pps_dly(pps_dly),
      .frq_stb(frq_stb), .frq_err(frq_err), .frq_set(frq_set), .blank(blank),
      .out_rdy(out_rdy), .out_vld(out_vld), .out_byte(out_byte), .uart_ovf(uart_ovf)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step();
      int  fsz = q_fifo.size();
      bit  tm = 0, tp = 0, tf = 0;
      logic [7:0] b;
      if (q_seq.size() != 0) begin
         if (out_rdy) void'(q_seq.pop_front());
      end else if (m_p) begin
         q_seq = '{8'hBE}; tm = 1;
      end else if (p_p) begin
         q_seq = '{8'hBD, 8'h14, p_d[39:32], p_d[31:24], p_d[23:16], p_d[15:8], p_d[7:0]};
         tp = 1;
      end else if (f_p) begin
         q_seq = '{8'hBD, 8'h15, f_d[47:40], f_d[39:32], f_d[31:24], f_d[23:16],
                   f_d[15:8], f_d[7:0]};
         tf = 1;
      end else if (!blank && fsz > 0) begin
         b = q_fifo.pop_front();
         if (b == 8'hBD)      q_seq = '{8'hBD, 8'h00};
         else if (b == 8'hBE) q_seq = '{8'hBD, 8'h01};
         else                 q_seq = '{b};
      end
      if (uart_vld) begin
         if (fsz < 16) q_fifo.push_back(uart_data);
         else          m_ovf = 1;
      end
      m_p = mark_stb | (m_p & !tm);
      p_p = pps_stb | (p_p & !tp);
      f_p = frq_stb | (f_p & !tf);
      if (pps_stb) p_d = {pps_ts, pps_dly};
      if (frq_stb) f_d = {frq_err, frq_set};
   endtask

   task automatic compare();
      bit ev = (q_seq.size() != 0);
      chk(out_vld == ev, cur_req, 64'(out_vld), 64'(ev));
      if (ev) chk(out_byte == q_seq[0], cur_req, 64'(out_byte), 64'(q_seq[0]));
      chk(uart_ovf == m_ovf, cur_req, 64'(uart_ovf), 64'(m_ovf));
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      uart_vld = 1'b0; mark_stb = 1'b0; pps_stb = 1'b0; frq_stb = 1'b0;
   endtask

   task automatic idle_n(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic send_uart(input logic [7:0] d);
      uart_vld = 1'b1; uart_data = d; cyc();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      chk(out_vld == 1'b0, "R1", 64'(out_vld), 0);
      chk(uart_ovf == 1'b0, "R1", 64'(uart_ovf), 0);
      rst_n = 1'b1;
      idle_n(3);

      // R2: mark from idle shows two edges after the strobe
      cur_req = "R2";
      mark_stb = 1'b1; cyc(); cyc();
      chk(out_vld && out_byte == 8'hBE, "R2", 64'(out_byte), 64'hBE);
      idle_n(3);

      // R4: plain bytes pass unchanged
      cur_req = "R4";
      send_uart(8'h00); send_uart(8'h41); send_uart(8'hFF); send_uart(8'hBC);
      idle_n(10);

      // R3: reserved bytes are stuffed
      cur_req = "R3";
      send_uart(8'hBD); send_uart(8'hBE); send_uart(8'h20);
      idle_n(10);

      // R5: timestamp report, latest values win
      cur_req = "R5";
      pps_ts = 32'h11223344; pps_dly = 8'h07; pps_stb = 1'b1; cyc();
      idle_n(12);
      pps_ts = 32'hDEADBEEF; pps_dly = 8'h1F; pps_stb = 1'b1; cyc();
      pps_ts = 32'hCAFEF00D; pps_dly = 8'h02; pps_stb = 1'b1; cyc();
      idle_n(12);

      // R6: frequency report with negative error
      cur_req = "R6";
      frq_err = 32'hFFFFFFF6; frq_set = 16'h8001; frq_stb = 1'b1; cyc();
      idle_n(12);
      frq_err = 32'h00000BBE; frq_set = 16'h0000; frq_stb = 1'b1; cyc();
      idle_n(12);

      // R7: all sources at once, and a mark arriving mid-report
      cur_req = "R7";
      pps_ts = 32'h01020304; pps_dly = 8'h03;
      frq_err = 32'h0A0B0C0D; frq_set = 16'h1234;
      mark_stb = 1'b1; pps_stb = 1'b1; frq_stb = 1'b1;
      uart_vld = 1'b1; uart_data = 8'h55; cyc();
      idle_n(4);
      mark_stb = 1'b1; uart_vld = 1'b1; uart_data = 8'hBE; cyc();
      idle_n(25);

      // R8: blanking holds UART data but not marks or reports
      cur_req = "R8";
      blank = 1'b1;
      for (int i = 0; i < 5; i++) send_uart(8'h30 + 8'(i));
      mark_stb = 1'b1; cyc();
      pps_stb = 1'b1; cyc();
      idle_n(20);
      chk(out_vld == 1'b0, "R8", 64'(out_vld), 0);
      blank = 1'b0;
      idle_n(15);

      // R10: back-pressure with a varying ready pattern
      cur_req = "R10";
      frq_stb = 1'b1; uart_vld = 1'b1; uart_data = 8'hBD; cyc();
      for (int i = 0; i < 60; i++) begin
         out_rdy = ((i * 7) % 3) != 0;
         if (i == 5)  begin mark_stb = 1'b1; end
         if (i == 9)  begin uart_vld = 1'b1; uart_data = 8'h77; end
         if (i == 12) begin pps_stb = 1'b1; end
         cyc();
      end
      out_rdy = 1'b1;
      idle_n(20);

      // R9: overflow when full, sticky, stored bytes still drain
      cur_req = "R9";
      blank = 1'b1;
      for (int i = 0; i < 20; i++) send_uart(8'h60 + 8'(i));
      chk(uart_ovf == 1'b1, "R9", 64'(uart_ovf), 1);
      blank = 1'b0;
      idle_n(40);
      chk(uart_ovf == 1'b1, "R9", 64'(uart_ovf), 1);

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule